// File: doc/BRIEF.md
# Image Sensor Register Setup Sequencer

This block takes an image sensor from power-up to a fully programmed state. When reset is released it takes the sensor out of power-down and out of reset. It then waits a fixed settling time and writes a list of register address and value pairs to the sensor, one two-wire (I2C) write transaction per pair. When the final pair has been written, it raises a completion flag. That flag stays high and serves as the enable and reset-release for the capture logic downstream.

The serial clock is a push-pull output. The data line is open-drain: the block only ever pulls it low or releases it, and a board pull-up provides the high level. The bus speed comes from a clock divider parameter. Both the settling delay and the number of table entries are parameters. The table contents are computed from the entry index, so no stored list is needed. The block ignores acknowledge bits: it does not read back, support clock stretching or arbitrate between masters. There is no data stream at its boundary, so all pins are plain control and status.

Top module: `cam_cfg_seq`

## Requirements
- R1: While `rst_n` is low: `cam_scl` is 1, `cam_sda` is released (reads 1 through the pull-up), `cfg_done` is 0, `cam_pwdn` is 1 and `cam_rst_n` is 0.
- R2: On the first rising clock edge after `rst_n` goes high, `cam_pwdn` becomes 0 and `cam_rst_n` becomes 1. Both hold those values until the next reset.
- R3: For the first DELAY_CYCLES clock cycles after reset release, the bus stays idle (SCL high, SDA released). The first START condition follows within DELAY_CYCLES + 2*CLK_DIV + 8 cycles of release.
- R4: Each write is framed as follows: START, the byte {DEV_ADDR, 0} sent MSB first, an acknowledge slot, the register address byte, an acknowledge slot, the data byte, an acknowledge slot, then STOP. That is exactly 27 SCL high pulses between START and STOP.
- R5: Inside a transaction, SDA changes only while SCL is low. The only exceptions are START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high).
- R6: SDA is never driven high. It is released for every 1 bit and in all three acknowledge slots, so those slots read 1 when no device answers.
- R7: During each data or acknowledge bit, SCL stays high for exactly 2*CLK_DIV clock cycles.
- R8: Entry k (counting from 0) writes register address k mod 256 with value (37*k + 11) mod 256. Entries are written in increasing k, and exactly NUM_REGS writes are made.
- R9: `cfg_done` is 0 when the final STOP appears and rises within 3*CLK_DIV + 4 cycles after it. It then stays 1 until reset, and the bus stays idle.
- R10: A reset asserted at any point, including partway through a transaction, restores the R1 state at once. After release, the block repeats the full delay and restarts the table from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_scl | output | 1 | Serial bus clock to the sensor |
| cam_sda | inout | 1 | Open-drain serial data; pulled low or released |
| cam_pwdn | output | 1 | Sensor power-down, active high |
| cam_rst_n | output | 1 | Sensor reset, active low |
| cfg_done | output | 1 | Sticky completion flag; enables downstream capture |

## Verification
The bench decodes the bus at the pins. It rebuilds every byte from SCL rising edges and checks framing, the table values and the order of entries. A table generator with an off-by-one index or a wrong formula would show up as a mismatched address or value. A shift register that drops or repeats a bit would produce 26 or 28 pulses, or a shifted byte. Resets are injected at random points, including inside transactions; a sequencer that kept its index or skipped the settling delay after such a reset would start at a non-zero entry or start too early. The bench also watches the bus around the last STOP: a completion flag raised one write early, or bus activity after completion, is reported.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;

  typedef enum logic [1:0] {
    SQ_WAIT,
    SQ_ISSUE,
    SQ_BUSY,
    SQ_DONE
  } seq_st_t;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_START,
    EN_BITS,
    EN_STOP
  } eng_st_t;

  // Bits on the wire per write: three bytes, each followed by an acknowledge slot.
  localparam int unsigned FRAME_BITS = 27;

  function automatic logic [7:0] entry_addr(int unsigned k);
    return k[7:0];
  endfunction

  function automatic logic [7:0] entry_val(int unsigned k);
    int unsigned t;
    t = k * 37 + 11;
    return t[7:0];
  endfunction

endpackage

// File: rtl/cam_cfg_delay.sv
module cam_cfg_delay #(
  parameter int unsigned DELAY_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired
);
  generate
    if (DELAY_CYCLES == 0) begin : g_none
      assign expired = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DELAY_CYCLES + 1);
      logic [CW-1:0] cnt;
      logic          exp_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt   <= '0;
          exp_q <= 1'b0;
        end else if (!exp_q) begin
          if (cnt == CW'(DELAY_CYCLES - 1)) exp_q <= 1'b1;
          else                              cnt   <= cnt + 1'b1;
        end
      end

      assign expired = exp_q;
    end
  endgenerate
endmodule

// File: rtl/cam_cfg_rom.sv
module cam_cfg_rom #(
  parameter int unsigned NUM_REGS = 252,
  localparam int unsigned IW = $clog2(NUM_REGS + 1)
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    addr,
  output logic [7:0]    val
);
  import cam_cfg_pkg::*;

  always_comb begin
    addr = entry_addr(int'(idx));
    val  = entry_val(int'(idx));
  end
endmodule

// File: rtl/cam_cfg_i2c_wr.sv
module cam_cfg_i2c_wr #(
  parameter int unsigned CLK_DIV = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] dev,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_val,
  output logic       busy,
  output logic       in_bits,
  output logic       done,
  output logic       scl,
  output logic       sda_low
);
  import cam_cfg_pkg::*;

  localparam int unsigned DW = $clog2(CLK_DIV + 1);
  localparam int unsigned BW = $clog2(FRAME_BITS);

  eng_st_t                 st;
  logic [DW-1:0]           div;
  logic [1:0]              q;
  logic [BW-1:0]           bcnt;
  logic [FRAME_BITS-1:0]   sh;
  logic                    tick;

  assign tick = (div == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= EN_IDLE;
      div  <= '0;
      q    <= '0;
      bcnt <= '0;
      sh   <= '1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == EN_IDLE) begin
        if (start) begin
          st   <= EN_START;
          div  <= '0;
          q    <= '0;
          bcnt <= '0;
          // A 1 in an acknowledge slot leaves the line released.
          sh   <= {dev, 1'b0, 1'b1, reg_addr, 1'b1, reg_val, 1'b1};
        end
      end else if (tick) begin
        div <= '0;
        q   <= q + 2'd1;
        if (q == 2'd3) begin
          unique case (st)
            EN_START: st <= EN_BITS;
            EN_BITS: begin
              sh <= {sh[FRAME_BITS-2:0], 1'b1};
              if (bcnt == BW'(FRAME_BITS - 1)) st <= EN_STOP;
              else                             bcnt <= bcnt + 1'b1;
            end
            EN_STOP: begin
              st   <= EN_IDLE;
              done <= 1'b1;
            end
            default: st <= EN_IDLE;
          endcase
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (st)
      EN_START: begin scl = (q < 2'd2);              sda_low = (q != 2'd0); end
      EN_BITS:  begin scl = (q == 2'd1 || q == 2'd2); sda_low = !sh[FRAME_BITS-1]; end
      EN_STOP:  begin scl = (q != 2'd0);             sda_low = (q < 2'd2); end
      default:  begin scl = 1'b1;                    sda_low = 1'b0; end
    endcase
  end

  assign busy    = (st != EN_IDLE);
  assign in_bits = (st == EN_BITS);
endmodule

// File: rtl/cam_cfg_seq.sv
module cam_cfg_seq #(
  parameter int unsigned DELAY_CYCLES = 1000000,
  parameter int unsigned NUM_REGS     = 252,
  parameter int unsigned CLK_DIV      = 125,
  parameter logic [6:0]  DEV_ADDR     = 7'h21
) (
  input  logic clk,
  input  logic rst_n,
  output logic cam_scl,
  inout  wire  cam_sda,
  output logic cam_pwdn,
  output logic cam_rst_n,
  output logic cfg_done
);
  import cam_cfg_pkg::*;

  localparam int unsigned IW = $clog2(NUM_REGS + 1);

  seq_st_t       st;
  logic [IW-1:0] idx;
  logic          expired;
  logic [7:0]    rom_addr;
  logic [7:0]    rom_val;
  logic          eng_start;
  logic          eng_busy;
  logic          eng_in_bits;
  logic          eng_done;
  logic          eng_sda_low;
  logic          st_wait;

  cam_cfg_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .expired (expired)
  );

  cam_cfg_rom #(.NUM_REGS(NUM_REGS)) u_rom (
    .idx  (idx),
    .addr (rom_addr),
    .val  (rom_val)
  );

  cam_cfg_i2c_wr #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .dev      (DEV_ADDR),
    .reg_addr (rom_addr),
    .reg_val  (rom_val),
    .busy     (eng_busy),
    .in_bits  (eng_in_bits),
    .done     (eng_done),
    .scl      (cam_scl),
    .sda_low  (eng_sda_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_WAIT;
      idx      <= '0;
      cfg_done <= 1'b0;
    end else begin
      unique case (st)
        SQ_WAIT:  if (expired) st <= SQ_ISSUE;
        SQ_ISSUE: st <= SQ_BUSY;
        SQ_BUSY: begin
          if (eng_done) begin
            if (idx == IW'(NUM_REGS - 1)) begin
              st       <= SQ_DONE;
              cfg_done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              st  <= SQ_ISSUE;
            end
          end
        end
        default: st <= SQ_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cam_pwdn  <= 1'b1;
      cam_rst_n <= 1'b0;
    end else begin
      cam_pwdn  <= 1'b0;
      cam_rst_n <= 1'b1;
    end
  end

  assign eng_start = (st == SQ_ISSUE);
  assign st_wait   = (st == SQ_WAIT);
  assign cam_sda   = eng_sda_low ? 1'b0 : 1'bz;
endmodule

// File: rtl/cam_cfg_seq_chk.sv
module cam_cfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic sda_low,
  input logic done,
  input logic pwdn,
  input logic srst_n,
  input logic waiting,
  input logic start,
  input logic busy,
  input logic in_bits
);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_bus_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl && !sda_low));

  p_bus_quiet_in_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (scl && !sda_low));

  p_sda_steady_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bits && $past(in_bits) && scl && $past(scl)) |-> $stable(sda_low));

  p_start_only_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  p_sensor_pins_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |-> (!pwdn && srst_n));
endmodule

bind cam_cfg_seq cam_cfg_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl     (cam_scl),
  .sda_low (eng_sda_low),
  .done    (cfg_done),
  .pwdn    (cam_pwdn),
  .srst_n  (cam_rst_n),
  .waiting (st_wait),
  .start   (eng_start),
  .busy    (eng_busy),
  .in_bits (eng_in_bits)
);

// File: tb/cam_cfg_seq_test.sv
module cam_cfg_seq_test;
  localparam int unsigned DLY = 300;
  localparam int unsigned NR  = 9;
  localparam int unsigned DIV = 4;
  localparam logic [6:0]  DEV = 7'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  wire  cam_sda;
  logic cam_scl, cam_pwdn, cam_rst_n, cfg_done;

  pullup (cam_sda);

  always #10 clk = ~clk;

  cam_cfg_seq #(.DELAY_CYCLES(DLY), .NUM_REGS(NR), .CLK_DIV(DIV), .DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .cam_scl(cam_scl), .cam_sda(cam_sda),
    .cam_pwdn(cam_pwdn), .cam_rst_n(cam_rst_n), .cfg_done(cfg_done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(int k); return k % 256; endfunction
  function automatic int exp_val(int k);  return (37 * k + 11) % 256; endfunction

  // Bus decoder state
  int cyc = 0, nb = 0, ntx = 0, hc = 0, last_stop = 0;
  bit in_frame = 0, seen_start = 0, pscl = 1, psda = 1;
  logic [26:0] sh = '0;

  always @(negedge clk) begin
    bit s, d;
    if (!rst_n) begin
      cyc = 0; nb = 0; ntx = 0; hc = 0; in_frame = 0; seen_start = 0;
      pscl = 1; psda = 1;
    end else begin
      cyc++;
      s = cam_scl;
      d = (cam_sda !== 1'b0);
      if (pscl && s && psda && !d) begin
        chk(!in_frame, "R5 START inside frame", in_frame, 0);
        if (!seen_start) begin
          chk(cyc > DLY && cyc <= DLY + 2*DIV + 8, "R3 first START cycle", cyc, DLY);
          seen_start = 1;
        end
        in_frame = 1; nb = 0; sh = '0;
      end else if (pscl && s && !psda && d) begin
        chk(in_frame, "R5 stray STOP", in_frame, 1);
        if (in_frame) begin
          chk(nb == 27, "R4 SCL pulses per write", nb, 27);
          chk(sh[26:19] == {DEV, 1'b0}, "R4 device byte", sh[26:19], {DEV, 1'b0});
          chk(sh[17:10] == exp_addr(ntx), "R8 register address", sh[17:10], exp_addr(ntx));
          chk(sh[8:1] == exp_val(ntx), "R8 register value", sh[8:1], exp_val(ntx));
          chk(ntx < NR, "R8 write count bound", ntx, NR);
          if (ntx == NR - 1) begin
            last_stop = cyc;
            chk(cfg_done == 1'b0, "R9 done low at last STOP", cfg_done, 0);
          end
          ntx++;
        end
        in_frame = 0;
      end else if (!pscl && s) begin
        if (in_frame && nb < 27) begin
          sh = {sh[25:0], d};
          if (nb == 8 || nb == 17 || nb == 26) chk(d, "R6 ack slot released", d, 1);
          nb++;
        end
        hc = 1;
      end else if (pscl && s) begin
        hc++;
      end else if (pscl && !s) begin
        if (in_frame && nb > 0) chk(hc == 2*DIV, "R7 SCL high length", hc, 2*DIV);
      end
      if (cfg_done && (!s || !d)) chk(0, "R9 bus active after done", s, 1);
      pscl = s; psda = d;
    end
  end

  task automatic hold_reset(input int n);
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (n) @(negedge clk);
    chk(cam_scl == 1'b1, "R1 scl in reset", cam_scl, 1);
    chk(cam_sda === 1'b1, "R1 sda released in reset", cam_sda, 1);
    chk(cfg_done == 1'b0, "R1 R10 done in reset", cfg_done, 0);
    chk(cam_pwdn == 1'b1, "R1 pwdn in reset", cam_pwdn, 1);
    chk(cam_rst_n == 1'b0, "R1 sensor reset in reset", cam_rst_n, 0);
  endtask

  task automatic release_reset();
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cam_pwdn == 1'b0, "R2 pwdn after release", cam_pwdn, 0);
    chk(cam_rst_n == 1'b1, "R2 sensor reset after release", cam_rst_n, 1);
  endtask

  task automatic finish_run(input string tag);
    int w = 0;
    while (!cfg_done && w < 40000) begin @(negedge clk); w++; end
    chk(cfg_done == 1'b1, {tag, " R9 done reached"}, cfg_done, 1);
    chk(cyc - last_stop <= 3*DIV + 4, "R9 done latency", cyc - last_stop, 3*DIV + 4);
    chk(ntx == NR, {tag, " R8 total writes"}, ntx, NR);
    repeat (200) @(negedge clk);
    chk(cfg_done == 1'b1, "R9 done sticky", cfg_done, 1);
    chk(ntx == NR, "R9 no writes after done", ntx, NR);
    chk(cam_pwdn == 1'b0 && cam_rst_n == 1'b1, "R2 pins held", cam_pwdn, 0);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd4242);
    hold_reset(3);
    release_reset();
    finish_run("R10 first");
    for (int i = 0; i < 4; i++) begin
      int mid;
      hold_reset($urandom_range(2, 9));
      release_reset();
      mid = (i == 0) ? 50 : $urandom_range(DLY + 20, DLY + 4 * 29 * 4 * DIV);
      repeat (mid) @(negedge clk);
      hold_reset($urandom_range(1, 6));
      release_reset();
      finish_run("R10 after mid reset");
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule